// File: doc/BRIEF.md
# Temperature Step Table Fan Duty Controller

This block turns one temperature reading into an 8-bit duty request for a single fan output. A 13-entry step table maps temperature bands to duty values. The threshold of each band is a shared base temperature plus a per-step offset. A minimum-duty floor and a falling-edge hysteresis keep the fan from chattering near a threshold. The table result is merged with a request from a separate proportional-integral loop, and the larger of the two is used.

Two conditions override the table and drive the duty to full scale (255). The first is a temperature boost, which latches when the reading reaches a boost temperature and is held until the reading falls a programmable margin below it. The second is a tachometer fault, which holds the boost for a programmable number of millisecond ticks after the fault clears. The step register and the boost state update on each clock edge. The output is combinational from that registered state and from the current proportional-integral request.

Top module: `fan_lut_duty`

## Requirements
- R1: After reset the step index is 0, no boost is active and the hold count is 0, so the duty equals max(`min_duty`, `pi_duty`).
- R2: On a clock edge, if the highest step k (1..13) whose threshold `base_temp + offset[k]` is at or below the effective temperature is above the current step, the step becomes k. The duty is then the step's table value. Temperatures are unsigned in 0.5 °C units. Step k uses offset bits [6k-1:6k-6] and duty bits [8k-1:8k-8].
- R3: The step falls only to the highest step whose threshold is at or below temperature + `step_hyst`. While temperature + `step_hyst` still reaches the current threshold, the step holds. A fall may skip several steps in one edge.
- R4: The table duty is never below `min_duty`. At step 0 it equals `min_duty`, and a step value below the floor is raised to it.
- R5: Without a boost, the duty is the larger of the table duty and `pi_duty`.
- R6: A temperature at or above `boost_temp` sets the temperature boost at the next edge, and the duty is then 255.
- R7: The temperature boost clears only when temperature + `boost_hyst` < `boost_temp`. Readings between that point and `boost_temp` keep the current boost state.
- R8: While `tach_fault` is high the duty is 255. After it drops, the boost holds until `hold_ms` pulses of `ms_tick` have been counted.
- R9: Each clock edge with `tach_fault` high reloads the hold count with `hold_ms`, which restarts a hold already in progress.
- R10: With `coarse_res` = 1 the temperature's least significant bit is cleared before any comparison (1.0 °C resolution). With 0, all bits are used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| temp | input | 10 | Temperature reading, 0.5 °C per LSB |
| coarse_res | input | 1 | 1 = compare at 1.0 °C resolution |
| base_temp | input | 10 | Base temperature for all step thresholds |
| step_offset | input | 78 | Thirteen 6-bit step offsets, step 1 in the low bits |
| step_duty | input | 104 | Thirteen 8-bit step duty values, step 1 in the low bits |
| min_duty | input | 8 | Minimum duty floor of the table |
| step_hyst | input | 4 | Falling-temperature hysteresis for steps |
| boost_temp | input | 10 | Temperature boost threshold |
| boost_hyst | input | 5 | Release margin below the boost threshold |
| pi_duty | input | 8 | Duty request from the proportional-integral loop |
| tach_fault | input | 1 | Fan tachometer limit fault |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| hold_ms | input | 8 | Minimum boost hold after a tach fault, in ticks |
| duty | output | 8 | Duty request, 255 = full speed |

## Verification
The step table is exercised with a rising sweep that lands exactly on a threshold and between thresholds, which separates an at-or-below comparison from a strictly-below one. Falling readings that stay inside the hysteresis band and then leave it distinguish holding a step from dropping it, and one large drop shows that several steps fall together. Proportional-integral requests above and below the table value separate the maximum merge from a plain override. A reading one half-degree under an odd threshold, taken in both resolution modes, shows the effect of coarse rounding. Boost readings placed inside the release band, and tach faults repeated partway through a hold, separate a latched boost and a restarted timer from naive level versions.

// File: rtl/fan_lut_pkg.sv
package fan_lut_pkg;

  localparam int DUTY_W = 8;
  localparam logic [DUTY_W-1:0] DUTY_FULL = '1;

  // larger of two duty values
  function automatic logic [DUTY_W-1:0] duty_max(input logic [DUTY_W-1:0] a,
                                                 input logic [DUTY_W-1:0] b);
    return (a > b) ? a : b;
  endfunction

  // clear the half-degree bit when coarse resolution is selected
  function automatic logic [15:0] round_temp(input logic [15:0] t, input logic coarse);
    logic [15:0] r;
    r = t;
    if (coarse) r[0] = 1'b0;
    return r;
  endfunction

  // threshold of one step: base plus offset, one bit wider than the base
  function automatic logic [16:0] step_threshold(input logic [15:0] base,
                                                 input logic [15:0] off);
    return {1'b0, base} + {1'b0, off};
  endfunction

endpackage

// File: rtl/lut_step_tracker.sv
module lut_step_tracker
  import fan_lut_pkg::*;
#(
  parameter int NSTEPS = 13,
  parameter int TW     = 10,
  parameter int OW     = 6,
  parameter int HW     = 4,
  parameter int SW     = $clog2(NSTEPS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [TW-1:0]        t_eff,
  input  logic [TW-1:0]        base_temp,
  input  logic [NSTEPS*OW-1:0] step_offset,
  input  logic [HW-1:0]        step_hyst,
  output logic [SW-1:0]        cur_step,
  output logic [SW-1:0]        rise_step,
  output logic [SW-1:0]        fall_step
);

  localparam int XW = TW + 1;

  logic [XW-1:0]     thr [NSTEPS];
  logic [NSTEPS-1:0] hit_rise;
  logic [NSTEPS-1:0] hit_fall;
  logic [XW-1:0]     t_wide;
  logic [XW-1:0]     t_plus_h;
  logic [SW-1:0]     next_step;

  assign t_wide   = {1'b0, t_eff};
  assign t_plus_h = t_wide + XW'(step_hyst);

  generate
    for (genvar g = 0; g < NSTEPS; g++) begin : g_thr
      logic [16:0] full_thr;
      assign full_thr    = step_threshold(16'(base_temp), 16'(step_offset[g*OW +: OW]));
      assign thr[g]      = full_thr[XW-1:0];
      assign hit_rise[g] = (t_wide >= thr[g]);
      assign hit_fall[g] = (t_plus_h >= thr[g]);
    end
  endgenerate

  // highest hit index for each comparison set
  always_comb begin
    rise_step = '0;
    fall_step = '0;
    for (int k = 0; k < NSTEPS; k++) begin
      if (hit_rise[k]) rise_step = SW'(k + 1);
      if (hit_fall[k]) fall_step = SW'(k + 1);
    end
  end

  always_comb begin
    if (rise_step > cur_step)      next_step = rise_step;
    else if (fall_step < cur_step) next_step = fall_step;
    else                           next_step = cur_step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_step <= '0;
    else        cur_step <= next_step;
  end

endmodule

// File: rtl/boost_ctrl.sv
module boost_ctrl #(
  parameter int TW  = 10,
  parameter int BHW = 5,
  parameter int CW  = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [TW-1:0]  t_eff,
  input  logic [TW-1:0]  boost_temp,
  input  logic [BHW-1:0] boost_hyst,
  input  logic           tach_fault,
  input  logic           ms_tick,
  input  logic [CW-1:0]  hold_ms,
  output logic           temp_boost,
  output logic [CW-1:0]  hold_cnt,
  output logic           tach_boost,
  output logic           boost_any
);

  localparam int XW = TW + 1;

  logic boost_set;
  logic boost_clr;
  logic [XW-1:0] t_plus_bh;

  assign t_plus_bh = {1'b0, t_eff} + XW'(boost_hyst);
  assign boost_set = (t_eff >= boost_temp);
  assign boost_clr = (t_plus_bh < {1'b0, boost_temp});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         temp_boost <= 1'b0;
    else if (boost_set) temp_boost <= 1'b1;
    else if (boost_clr) temp_boost <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          hold_cnt <= '0;
    else if (tach_fault)                 hold_cnt <= hold_ms;
    else if (ms_tick && hold_cnt != '0)  hold_cnt <= hold_cnt - 1'b1;
  end

  assign tach_boost = tach_fault || (hold_cnt != '0);
  assign boost_any  = temp_boost || tach_boost;

endmodule

// File: rtl/duty_merge.sv
module duty_merge
  import fan_lut_pkg::*;
#(
  parameter int NSTEPS = 13,
  parameter int SW     = $clog2(NSTEPS + 1)
) (
  input  logic [SW-1:0]            cur_step,
  input  logic [NSTEPS*DUTY_W-1:0] step_duty,
  input  logic [DUTY_W-1:0]        min_duty,
  input  logic [DUTY_W-1:0]        pi_duty,
  input  logic                     boost,
  output logic [DUTY_W-1:0]        table_duty,
  output logic [DUTY_W-1:0]        duty
);

  logic [DUTY_W-1:0] raw_duty;

  always_comb begin
    raw_duty = '0;
    for (int k = 1; k <= NSTEPS; k++) begin
      if (cur_step == SW'(k)) raw_duty = step_duty[(k-1)*DUTY_W +: DUTY_W];
    end
  end

  assign table_duty = duty_max(raw_duty, min_duty);
  assign duty       = boost ? DUTY_FULL : duty_max(table_duty, pi_duty);

endmodule

// File: rtl/fan_lut_duty.sv
module fan_lut_duty
  import fan_lut_pkg::*;
#(
  parameter int NSTEPS = 13,
  parameter int TW     = 10,
  parameter int OW     = 6,
  parameter int HW     = 4,
  parameter int BHW    = 5,
  parameter int CW     = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [TW-1:0]            temp,
  input  logic                     coarse_res,
  input  logic [TW-1:0]            base_temp,
  input  logic [NSTEPS*OW-1:0]     step_offset,
  input  logic [NSTEPS*DUTY_W-1:0] step_duty,
  input  logic [DUTY_W-1:0]        min_duty,
  input  logic [HW-1:0]            step_hyst,
  input  logic [TW-1:0]            boost_temp,
  input  logic [BHW-1:0]           boost_hyst,
  input  logic [DUTY_W-1:0]        pi_duty,
  input  logic                     tach_fault,
  input  logic                     ms_tick,
  input  logic [CW-1:0]            hold_ms,
  output logic [DUTY_W-1:0]        duty
);

  localparam int SW = $clog2(NSTEPS + 1);

  logic [15:0]       t_round;
  logic [TW-1:0]     t_eff;
  logic [SW-1:0]     cur_step;
  logic [SW-1:0]     rise_step;
  logic [SW-1:0]     fall_step;
  logic              temp_boost;
  logic              tach_boost;
  logic              boost_any;
  logic [CW-1:0]     hold_cnt;
  logic [DUTY_W-1:0] table_duty;

  assign t_round = round_temp(16'(temp), coarse_res);
  assign t_eff   = t_round[TW-1:0];

  lut_step_tracker #(
    .NSTEPS(NSTEPS), .TW(TW), .OW(OW), .HW(HW), .SW(SW)
  ) u_steps (
    .clk        (clk),
    .rst_n      (rst_n),
    .t_eff      (t_eff),
    .base_temp  (base_temp),
    .step_offset(step_offset),
    .step_hyst  (step_hyst),
    .cur_step   (cur_step),
    .rise_step  (rise_step),
    .fall_step  (fall_step)
  );

  boost_ctrl #(
    .TW(TW), .BHW(BHW), .CW(CW)
  ) u_boost (
    .clk       (clk),
    .rst_n     (rst_n),
    .t_eff     (t_eff),
    .boost_temp(boost_temp),
    .boost_hyst(boost_hyst),
    .tach_fault(tach_fault),
    .ms_tick   (ms_tick),
    .hold_ms   (hold_ms),
    .temp_boost(temp_boost),
    .hold_cnt  (hold_cnt),
    .tach_boost(tach_boost),
    .boost_any (boost_any)
  );

  duty_merge #(
    .NSTEPS(NSTEPS), .SW(SW)
  ) u_merge (
    .cur_step  (cur_step),
    .step_duty (step_duty),
    .min_duty  (min_duty),
    .pi_duty   (pi_duty),
    .boost     (boost_any),
    .table_duty(table_duty),
    .duty      (duty)
  );

endmodule

// File: rtl/fan_lut_duty_chk.sv
module fan_lut_duty_chk #(
  parameter int TW  = 10,
  parameter int BHW = 5,
  parameter int CW  = 8,
  parameter int SW  = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic [TW-1:0]  t_eff,
  input logic [TW-1:0]  boost_temp,
  input logic [BHW-1:0] boost_hyst,
  input logic [7:0]     min_duty,
  input logic [7:0]     pi_duty,
  input logic [7:0]     duty,
  input logic           tach_fault,
  input logic           ms_tick,
  input logic [CW-1:0]  hold_ms,
  input logic [CW-1:0]  hold_cnt,
  input logic           temp_boost,
  input logic           tach_boost,
  input logic [SW-1:0]  cur_step,
  input logic [SW-1:0]  rise_step
);

  // R2
  step_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_step > cur_step) |=> (cur_step == $past(rise_step)));

  // R4
  min_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    duty >= min_duty);

  // R5
  pi_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    duty >= pi_duty);

  // R6
  temp_boost_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (t_eff >= boost_temp) |=> (temp_boost && duty == 8'hFF));

  // R7
  temp_boost_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (temp_boost && ({1'b0, t_eff} + (TW+1)'(boost_hyst) >= {1'b0, boost_temp})) |=> temp_boost);

  // R8
  tach_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tach_boost |-> (duty == 8'hFF));

  // R8
  hold_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tach_fault && ms_tick && hold_cnt != '0) |=> (hold_cnt == $past(hold_cnt) - 1'b1));

  // R9
  hold_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tach_fault |=> (hold_cnt == $past(hold_ms)));

endmodule

bind fan_lut_duty fan_lut_duty_chk #(
  .TW(TW), .BHW(BHW), .CW(CW), .SW(SW)
) u_fan_lut_duty_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .t_eff     (t_eff),
  .boost_temp(boost_temp),
  .boost_hyst(boost_hyst),
  .min_duty  (min_duty),
  .pi_duty   (pi_duty),
  .duty      (duty),
  .tach_fault(tach_fault),
  .ms_tick   (ms_tick),
  .hold_ms   (hold_ms),
  .hold_cnt  (hold_cnt),
  .temp_boost(temp_boost),
  .tach_boost(tach_boost),
  .cur_step  (cur_step),
  .rise_step (rise_step)
);

// File: tb/test_fan_lut_duty.sv
`timescale 1ns/1ps
module test_fan_lut_duty;

  localparam int NSTEPS = 13;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [9:0]        temp = '0;
  logic              coarse_res = 1'b0;
  logic [9:0]        base_temp = 10'd81;
  logic [NSTEPS*6-1:0] step_offset;
  logic [NSTEPS*8-1:0] step_duty;
  logic [7:0]        min_duty = 8'd50;
  logic [3:0]        step_hyst = 4'd3;
  logic [9:0]        boost_temp = 10'd160;
  logic [4:0]        boost_hyst = 5'd10;
  logic [7:0]        pi_duty = '0;
  logic              tach_fault = 1'b0;
  logic              ms_tick = 1'b0;
  logic [7:0]        hold_ms = 8'd3;
  logic [7:0]        duty;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int    exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  fan_lut_duty i_fan_lut_duty (
    .clk(clk), .rst_n(rst_n), .temp(temp), .coarse_res(coarse_res),
    .base_temp(base_temp), .step_offset(step_offset), .step_duty(step_duty),
    .min_duty(min_duty), .step_hyst(step_hyst), .boost_temp(boost_temp),
    .boost_hyst(boost_hyst), .pi_duty(pi_duty), .tach_fault(tach_fault),
    .ms_tick(ms_tick), .hold_ms(hold_ms), .duty(duty)
  );

  // monitor: compare queued expectations away from the rising edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      int e;
      string tg;
      e  = exp_q.pop_front();
      tg = tag_q.pop_front();
      checks++;
      if (int'(duty) != e) begin
        errors++;
        $display("FAIL %s: duty actual %0d expected %0d", tg, duty, e);
      end
    end
  end

  // driver: set inputs after a falling edge, queue expected value after the rising edge
  task automatic apply(input int t, input int pi, input bit crs, input int mp,
                       input bit flt, input bit tk, input int exp, input string tag);
    @(negedge clk);
    #2;
    temp       = 10'(t);
    pi_duty    = 8'(pi);
    coarse_res = crs;
    min_duty   = 8'(mp);
    tach_fault = flt;
    ms_tick    = tk;
    @(posedge clk);
    #1;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
  endtask

  initial begin
    // thresholds 81 + 4(k-1), step duty 40 + 15k
    for (int k = 1; k <= NSTEPS; k++) begin
      step_offset[(k-1)*6 +: 6] = 6'(4*(k-1));
      step_duty[(k-1)*8 +: 8]   = 8'(40 + 15*k);
    end
    repeat (3) @(posedge clk);
    #3 rst_n = 1'b1;

    apply(0,   0, 0, 50, 0, 0, 50,  "R1 reset state");
    apply(70,  0, 0, 50, 0, 0, 50,  "R4 below step 1");
    apply(81,  0, 0, 50, 0, 0, 55,  "R2 exact step 1 threshold");
    apply(100, 0, 0, 50, 0, 0, 115, "R2 between thresholds step 5");
    apply(96,  0, 0, 50, 0, 0, 115, "R3 hold inside hysteresis");
    apply(93,  0, 0, 50, 0, 0, 100, "R3 drop to step 4");
    apply(93, 200, 0, 50, 0, 0, 200, "R5 pi above table");
    apply(93,  90, 0, 50, 0, 0, 100, "R5 table above pi");
    apply(70,  0, 0, 50, 0, 0, 50,  "R3 multi-step fall to 0");
    apply(81,  0, 1, 50, 0, 0, 50,  "R10 coarse rounds below step 1");
    apply(81,  0, 0, 50, 0, 0, 55,  "R10 fine reaches step 1");
    apply(81,  0, 0, 90, 0, 0, 90,  "R4 floor raises step value");
    apply(160, 0, 0, 50, 0, 0, 255, "R6 boost at threshold");
    apply(152, 0, 0, 50, 0, 0, 255, "R7 boost kept in band");
    apply(149, 0, 0, 50, 0, 0, 235, "R7 boost released");
    apply(159, 0, 0, 50, 0, 0, 235, "R7 no rearm below threshold");
    apply(70,  0, 0, 50, 0, 0, 50,  "R3 fall from step 13");
    apply(70,  0, 0, 50, 1, 0, 255, "R8 fault forces full");
    apply(70,  0, 0, 50, 0, 0, 255, "R8 hold after fault");
    apply(70,  0, 0, 50, 0, 1, 255, "R8 hold tick 1");
    apply(70,  0, 0, 50, 0, 1, 255, "R8 hold tick 2");
    apply(70,  0, 0, 50, 0, 1, 50,  "R8 hold expired");
    apply(70,  0, 0, 50, 1, 0, 255, "R9 first fault");
    apply(70,  0, 0, 50, 0, 1, 255, "R9 tick a");
    apply(70,  0, 0, 50, 0, 1, 255, "R9 tick b");
    apply(70,  0, 0, 50, 1, 0, 255, "R9 second fault");
    apply(70,  0, 0, 50, 0, 1, 255, "R9 tick c");
    apply(70,  0, 0, 50, 0, 1, 255, "R9 restarted hold");
    apply(70,  0, 0, 50, 0, 1, 50,  "R9 restarted hold expired");

    repeat (3) @(posedge clk);
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule